// File: doc/BRIEF.md
# Performance counter access port with width aliases

This block sits between a register-access request channel and a bank of event counters. It turns each request into either a write into counter storage or a read from it. Each general counter can be written through two aliases. The narrow alias takes only the low 32 bits of the data and sign-extends bit 31 up to the counter width. The wide alias stores the data unchanged, but it refuses any value with a bit set above the implemented counter width. Fixed counters have a single write path, which truncates to the fixed-counter width.

Reads use a packed 32-bit index. One flag bit chooses the fixed group and another chooses a fast mode that returns only the low 32 bits. The remaining bits give the counter number within the chosen group. A counter number that does not exist raises a fault in place of data. The same applies to a write to a counter that does not exist.

The storage is outside the block. The block drives a write port (enable, group, select, data) and a combinational read port (group, select, returned data) into it. Every request gets a response one clock later: a valid pulse, a fault pulse and the read data.

Top module: `ctr_access_port`

## Requirements
- R1: During and directly after reset, `rsp_valid` and `rsp_fault` are 0 and `rsp_rdata` is 0.
- R2: A write with `req_op` = 2'b01 (narrow alias) to general counter `req_index` stores `{sign of bit 31, wdata[31:0]}`, truncated to CTR_W bits. Data bits 63:32 have no effect on the stored value.
- R3: A write with `req_op` = 2'b10 (wide alias) whose bits at and above CTR_W are all zero stores the data unchanged and does not fault.
- R4: A wide-alias write with any bit set at or above CTR_W faults, and the addressed counter keeps its previous value.
- R5: A write with `req_op` = 2'b11 to fixed counter `req_index` stores the data truncated to FIX_W bits and never faults for an existing counter.
- R6: A read (`req_op` = 2'b00) with index bits 31 and 30 clear returns the full stored value of general counter `req_index[29:0]`. This holds whichever alias last wrote that counter. Write responses carry zero data.
- R7: A read with index bit 30 set addresses the fixed group by `req_index[29:0]`. Writes to one group never change a counter of the other group.
- R8: A read with index bit 31 set returns the low 32 bits of the addressed counter, with bits 63:32 zero.
- R9: A read whose counter number is not below the size of its group faults and returns zero data. Index 64 with no flags set is one such case.
- R10: A write whose `req_index` is not below the size of the addressed group faults and changes no counter.
- R11: A request accepted at a clock edge produces exactly one `rsp_valid` pulse, one cycle later. `rsp_fault` is a one-cycle pulse that can only accompany such a response, and an idle cycle gives no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 narrow general write, 10 wide general write, 11 fixed write |
| req_index | input | 32 | Counter number for writes; packed index for reads |
| req_wdata | input | 64 | Write data |
| st_we | output | 1 | Storage write enable |
| st_fix | output | 1 | Storage write targets fixed group |
| st_sel | output | SELW | Storage write counter select |
| st_wdata | output | WIDE | Storage write data |
| st_rfix | output | 1 | Storage read targets fixed group |
| st_rsel | output | SELW | Storage read counter select |
| st_rdata | input | WIDE | Storage read data (combinational) |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Fault pulse with the response |
| rsp_rdata | output | 64 | Read data, zero on fault or write |

## Verification
The hardest case to reach is a rejected wide write that leaves the counter untouched. It can only be observed after a later read, and that read must show the value left by whichever alias wrote last. The bench therefore sweeps every general counter through a list of data patterns. Each pattern is written through both aliases alternately, and each write is followed by a full read, a fast read and a fixed-group read. An oversized pattern is always preceded by a distinct valid value, so a leaked write shows up as a mismatch. Out-of-range writes are followed by a readback of every counter in both groups.

// File: rtl/ctr_access_pkg.sv
package ctr_access_pkg;

  typedef enum logic [1:0] {
    OP_READ      = 2'b00,
    OP_WR_NARROW = 2'b01,
    OP_WR_WIDE   = 2'b10,
    OP_WR_FIXED  = 2'b11
  } acc_op_e;

  localparam int IDX_FAST_BIT  = 31;
  localparam int IDX_GROUP_BIT = 30;
  localparam int IDX_NUM_W     = 30;
  localparam int BUS_W         = 64;

endpackage

// File: rtl/ctr_write_shaper.sv
module ctr_write_shaper
  import ctr_access_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int FIX_W = 40,
  parameter int N_GP  = 4,
  parameter int N_FX  = 3,
  parameter int WIDE  = 48,
  parameter int SELW  = 2
) (
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic [31:0]       index,
  input  logic [BUS_W-1:0]  wdata,
  output logic              we,
  output logic              fix,
  output logic [SELW-1:0]   sel,
  output logic [WIDE-1:0]   data,
  output logic              fault
);

  localparam logic [BUS_W-1:0] GP_MASK = (64'h1 << CTR_W) - 64'h1;
  localparam logic [BUS_W-1:0] FX_MASK = (64'h1 << FIX_W) - 64'h1;
  localparam logic [31:0]      GP_CNT  = 32'(N_GP);
  localparam logic [31:0]      FX_CNT  = 32'(N_FX);

  logic             is_wr;
  logic             range_ok;
  logic             too_wide;
  logic [BUS_W-1:0] sext;
  logic [BUS_W-1:0] shaped;

  assign is_wr    = valid && (op != OP_READ);
  assign fix      = (op == OP_WR_FIXED);
  assign range_ok = fix ? (index < FX_CNT) : (index < GP_CNT);
  // any set bit outside the implemented width rejects a wide write
  assign too_wide = (op == OP_WR_WIDE) && ((wdata & ~GP_MASK) != '0);
  assign sext     = {{32{wdata[31]}}, wdata[31:0]};

  always_comb begin
    unique case (op)
      OP_WR_NARROW: shaped = sext & GP_MASK;
      OP_WR_WIDE:   shaped = wdata & GP_MASK;
      OP_WR_FIXED:  shaped = wdata & FX_MASK;
      default:      shaped = '0;
    endcase
  end

  assign fault = is_wr && (!range_ok || too_wide);
  assign we    = is_wr && !fault;
  assign sel   = index[SELW-1:0];
  assign data  = shaped[WIDE-1:0];

endmodule

// File: rtl/ctr_read_path.sv
module ctr_read_path
  import ctr_access_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int FIX_W = 40,
  parameter int N_GP  = 4,
  parameter int N_FX  = 3,
  parameter int WIDE  = 48,
  parameter int SELW  = 2
) (
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic [31:0]       index,
  input  logic [WIDE-1:0]   st_rdata,
  output logic              rfix,
  output logic [SELW-1:0]   rsel,
  output logic              is_rd,
  output logic              fault,
  output logic [BUS_W-1:0]  data
);

  localparam logic [BUS_W-1:0]     GP_MASK = (64'h1 << CTR_W) - 64'h1;
  localparam logic [BUS_W-1:0]     FX_MASK = (64'h1 << FIX_W) - 64'h1;
  localparam logic [IDX_NUM_W-1:0] GP_CNT  = IDX_NUM_W'(N_GP);
  localparam logic [IDX_NUM_W-1:0] FX_CNT  = IDX_NUM_W'(N_FX);

  logic                 fast;
  logic [IDX_NUM_W-1:0] num;
  logic                 exists;
  logic [BUS_W-1:0]     wide_val;
  logic [BUS_W-1:0]     raw;

  assign is_rd  = valid && (op == OP_READ);
  assign rfix   = index[IDX_GROUP_BIT];
  assign fast   = index[IDX_FAST_BIT];
  assign num    = index[IDX_NUM_W-1:0];
  assign exists = rfix ? (num < FX_CNT) : (num < GP_CNT);
  assign rsel   = num[SELW-1:0];
  assign fault  = is_rd && !exists;

  // widen storage data to the bus, then trim to the group width
  generate
    if (WIDE < BUS_W) begin : g_pad
      assign wide_val = {{(BUS_W-WIDE){1'b0}}, st_rdata};
    end else begin : g_full
      assign wide_val = st_rdata;
    end
  endgenerate

  assign raw = wide_val & (rfix ? FX_MASK : GP_MASK);

  always_comb begin
    if (!is_rd || fault)  data = '0;
    else if (fast)        data = {32'h0, raw[31:0]};
    else                  data = raw;
  end

endmodule

// File: rtl/ctr_access_port.sv
module ctr_access_port
  import ctr_access_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int FIX_W = 40,
  parameter int N_GP  = 4,
  parameter int N_FX  = 3,
  parameter int WIDE  = (CTR_W > FIX_W) ? CTR_W : FIX_W,
  parameter int SELW  = ($clog2((N_GP > N_FX) ? N_GP : N_FX) < 1) ? 1
                       : $clog2((N_GP > N_FX) ? N_GP : N_FX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [31:0]      req_index,
  input  logic [63:0]      req_wdata,
  output logic             st_we,
  output logic             st_fix,
  output logic [SELW-1:0]  st_sel,
  output logic [WIDE-1:0]  st_wdata,
  output logic             st_rfix,
  output logic [SELW-1:0]  st_rsel,
  input  logic [WIDE-1:0]  st_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [63:0]      rsp_rdata
);

  logic             wr_fault;
  logic             rd_fault;
  logic             rd_sel;
  logic [BUS_W-1:0] rd_data;

  ctr_write_shaper #(
    .CTR_W(CTR_W), .FIX_W(FIX_W), .N_GP(N_GP), .N_FX(N_FX),
    .WIDE(WIDE), .SELW(SELW)
  ) u_wr (
    .valid (req_valid),
    .op    (req_op),
    .index (req_index),
    .wdata (req_wdata),
    .we    (st_we),
    .fix   (st_fix),
    .sel   (st_sel),
    .data  (st_wdata),
    .fault (wr_fault)
  );

  ctr_read_path #(
    .CTR_W(CTR_W), .FIX_W(FIX_W), .N_GP(N_GP), .N_FX(N_FX),
    .WIDE(WIDE), .SELW(SELW)
  ) u_rd (
    .valid    (req_valid),
    .op       (req_op),
    .index    (req_index),
    .st_rdata (st_rdata),
    .rfix     (st_rfix),
    .rsel     (st_rsel),
    .is_rd    (rd_sel),
    .fault    (rd_fault),
    .data     (rd_data)
  );

  // next-state
  logic             vld_d;
  logic             flt_d;
  logic [BUS_W-1:0] dat_d;
  logic             dat_en;

  always_comb begin
    vld_d  = req_valid;
    flt_d  = wr_fault || rd_fault;
    dat_en = req_valid;
    dat_d  = rd_sel ? rd_data : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
      rsp_fault <= flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (dat_en) rsp_rdata <= dat_d;
  end

endmodule

// File: rtl/ctr_access_chk.sv
module ctr_access_chk
  import ctr_access_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int N_GP  = 4,
  parameter int WIDE  = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [31:0]     req_index,
  input logic [63:0]     req_wdata,
  input logic            st_we,
  input logic [WIDE-1:0] st_wdata,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [63:0]     rsp_rdata
);

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_idle_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault));

  assert_wide_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WR_WIDE && (req_wdata >> CTR_W) != 64'h0) |-> !st_we);

  assert_wide_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WR_WIDE && (req_wdata >> CTR_W) != 64'h0) |=> rsp_fault);

  assert_narrow_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && req_op == OP_WR_NARROW) |->
      (st_wdata[31:0] == req_wdata[31:0] &&
       st_wdata[CTR_W-1:32] == {(CTR_W-32){req_wdata[31]}}));

  assert_fault_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_rdata == 64'h0));

  assert_fast_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_READ && req_index[IDX_FAST_BIT]) |=> (rsp_rdata[63:32] == 32'h0));

  assert_write_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_WR_NARROW || req_op == OP_WR_WIDE) &&
     req_index >= 32'(N_GP)) |-> !st_we);

endmodule

bind ctr_access_port ctr_access_chk #(
  .CTR_W(CTR_W), .N_GP(N_GP), .WIDE(WIDE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_index (req_index),
  .req_wdata (req_wdata),
  .st_we     (st_we),
  .st_wdata  (st_wdata),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_ctr_access_port.sv
module test_ctr_access_port;

  localparam int CTR_W = 48;
  localparam int FIX_W = 40;
  localparam int N_GP  = 4;
  localparam int N_FX  = 3;
  localparam int WIDE  = 48;
  localparam int SELW  = 2;
  localparam logic [63:0] GMASK = (64'h1 << CTR_W) - 64'h1;
  localparam logic [63:0] FMASK = (64'h1 << FIX_W) - 64'h1;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic [1:0]      req_op;
  logic [31:0]     req_index;
  logic [63:0]     req_wdata;
  logic            st_we, st_fix, st_rfix;
  logic [SELW-1:0] st_sel, st_rsel;
  logic [WIDE-1:0] st_wdata, st_rdata;
  logic            rsp_valid, rsp_fault;
  logic [63:0]     rsp_rdata;

  ctr_access_port #(.CTR_W(CTR_W), .FIX_W(FIX_W), .N_GP(N_GP), .N_FX(N_FX)) i_ctr_access_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_index(req_index), .req_wdata(req_wdata), .st_we(st_we), .st_fix(st_fix),
    .st_sel(st_sel), .st_wdata(st_wdata), .st_rfix(st_rfix), .st_rsel(st_rsel),
    .st_rdata(st_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // counter storage model
  logic [WIDE-1:0] m_gp [N_GP];
  logic [WIDE-1:0] m_fx [N_FX];
  always_ff @(posedge clk) begin
    if (st_we) begin
      if (st_fix) m_fx[st_sel] <= st_wdata;
      else        m_gp[st_sel] <= st_wdata;
    end
  end
  always_comb begin
    if (st_rfix) st_rdata = (int'(st_rsel) < N_FX) ? m_fx[st_rsel] : '0;
    else         st_rdata = (int'(st_rsel) < N_GP) ? m_gp[st_rsel] : '0;
  end

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] e_gp [N_GP];
  logic [63:0] e_fx [N_FX];
  logic        r_v, r_f;
  logic [63:0] r_d;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] idx, input logic [63:0] d);
    req_valid = 1'b1; req_op = op; req_index = idx; req_wdata = d;
    @(negedge clk);
    r_v = rsp_valid; r_f = rsp_fault; r_d = rsp_rdata;
    req_valid = 1'b0; req_op = 2'b00; req_index = '0; req_wdata = '0;
    chk("R11 rsp_valid", 64'(r_v), 64'h1);
  endtask

  function automatic logic [63:0] pat(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h0000_0000_7fff_ffff;
      2: return 64'h0000_0000_8000_0000;
      3: return 64'hffff_ff01_2345_6789;
      4: return 64'h0000_ff01_2345_6789;
      5: return 64'h0000_ffff_ffff_ffff;
      6: return 64'h0001_0000_0000_0000;
      default: return 64'h1234_5678_9abc_def0 ^ 64'(k);
    endcase
  endfunction

  task automatic read_all_check(input string req);
    for (int c = 0; c < N_GP; c++) begin
      issue(2'b00, 32'(c), 64'h0);
      chk(req, r_d, e_gp[c]);
    end
    for (int c = 0; c < N_FX; c++) begin
      issue(2'b00, 32'h4000_0000 | 32'(c), 64'h0);
      chk(req, r_d, e_fx[c]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_op = 2'b00; req_index = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid), 64'h0);
    chk("R1 fault in reset", 64'(rsp_fault), 64'h0);
    chk("R1 data in reset", rsp_rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(rsp_valid), 64'h0);
    chk("R1 data after reset", rsp_rdata, 64'h0);

    for (int c = 0; c < N_GP; c++) begin
      issue(2'b10, 32'(c), 64'h0); e_gp[c] = 64'h0;
    end
    for (int c = 0; c < N_FX; c++) begin
      issue(2'b11, 32'(c), 64'h0); e_fx[c] = 64'h0;
    end

    // general counters: both aliases across every pattern
    for (int c = 0; c < N_GP; c++) begin
      for (int k = 0; k < 8; k++) begin
        for (int a = 0; a < 2; a++) begin
          logic [63:0] p, exp_v;
          logic        bad;
          p = pat(k);
          // unique valid value first so a leaked write is visible
          issue(2'b10, 32'(c), 64'h0000_0abc_0000_0000 | 64'(k * 16 + a));
          e_gp[c] = 64'h0000_0abc_0000_0000 | 64'(k * 16 + a);
          if (a == 0) begin
            issue(2'b01, 32'(c), p);
            exp_v = {{32{p[31]}}, p[31:0]} & GMASK;
            chk("R2 narrow fault", 64'(r_f), 64'h0);
            chk("R6 write data zero", r_d, 64'h0);
            e_gp[c] = exp_v;
          end else begin
            issue(2'b10, 32'(c), p);
            bad = (p >> CTR_W) != 64'h0;
            if (bad) chk("R4 wide fault", 64'(r_f), 64'h1);
            else     chk("R3 wide no fault", 64'(r_f), 64'h0);
            if (!bad) e_gp[c] = p;
          end
          issue(2'b00, 32'(c), 64'h0);
          chk((a == 0) ? "R2 readback" : "R3 R4 readback", r_d, e_gp[c]);
          chk("R6 read no fault", 64'(r_f), 64'h0);
          issue(2'b00, 32'h8000_0000 | 32'(c), 64'h0);
          chk("R8 fast read", r_d, {32'h0, e_gp[c][31:0]});
          if (c < N_FX) begin
            issue(2'b00, 32'h4000_0000 | 32'(c), 64'h0);
            chk("R7 fixed untouched", r_d, e_fx[c]);
          end
        end
      end
    end

    // fixed counters
    for (int c = 0; c < N_FX; c++) begin
      for (int k = 0; k < 8; k++) begin
        issue(2'b11, 32'(c), pat(k));
        chk("R5 fixed write no fault", 64'(r_f), 64'h0);
        e_fx[c] = pat(k) & FMASK;
        issue(2'b00, 32'h4000_0000 | 32'(c), 64'h0);
        chk("R7 fixed read", r_d, e_fx[c]);
        issue(2'b00, 32'hc000_0000 | 32'(c), 64'h0);
        chk("R8 fast fixed read", r_d, {32'h0, e_fx[c][31:0]});
        issue(2'b00, 32'(c), 64'h0);
        chk("R7 general untouched", r_d, e_gp[c]);
      end
    end

    // nonexistent read indices
    for (int t = 0; t < 5; t++) begin
      logic [31:0] ix;
      case (t)
        0: ix = 32'd64;
        1: ix = 32'(N_GP);
        2: ix = 32'h4000_0000 | 32'(N_FX);
        3: ix = 32'h8000_0040;
        default: ix = 32'h0000_1000;
      endcase
      issue(2'b00, ix, 64'h0);
      chk("R9 read fault", 64'(r_f), 64'h1);
      chk("R9 read fault data", r_d, 64'h0);
      issue(2'b00, 32'd1, 64'h0);
      chk("R11 fault pulse ends", 64'(r_f), 64'h0);
      chk("R6 read after fault", r_d, e_gp[1]);
    end

    // nonexistent write targets
    issue(2'b01, 32'(N_GP), 64'hffff_ffff_ffff_ffff);
    chk("R10 narrow range fault", 64'(r_f), 64'h1);
    issue(2'b10, 32'd64, 64'h1);
    chk("R10 wide range fault", 64'(r_f), 64'h1);
    issue(2'b11, 32'(N_FX), 64'h55);
    chk("R10 fixed range fault", 64'(r_f), 64'h1);
    read_all_check("R10 counters unchanged");

    // idle cycle after a faulting request
    issue(2'b10, 32'd0, 64'hffff_0000_0000_0000);
    @(negedge clk);
    chk("R11 idle valid", 64'(rsp_valid), 64'h0);
    chk("R11 idle fault", 64'(rsp_fault), 64'h0);
    read_all_check("R4 counter kept");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule